// File: doc/BRIEF.md
# Flag-setting data-processing ALU

This block is the integer execute stage of a 32-bit datapath. It takes two operands, where the second has already been through a shift stage, and a 4-bit opcode that picks one of sixteen operations. It returns a 32-bit result, a write-enable for the destination register, and a new set of four condition flags: negative, zero, carry and overflow. The operations are add and subtract in both operand orders, with and without the incoming carry, four bitwise operations, two moves, and four compare/test forms that only update the flags.

The flags change only when the set-flags control is high, with one exception: the compare/test forms always update them. When no update is requested, the flags output repeats the incoming flags. Logical operations take their carry from the shifter's carry-out input and keep the incoming overflow flag. All outputs are registered, so each operation shows its results one clock after it is presented. A synchronous active-high reset clears the outputs.

Top module: `dp_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `result_o`=0, `wr_en_o`=0 and `flags_o`=0. Outside reset, every output reflects the inputs that were present at the previous rising edge.
- R2: The add-type opcodes are ADD=4 (a+b), ADC=5 (a+b+C) and CMN=11 (a+b). Here C is `flags_i[1]`. The carry flag takes the carry out of bit 31.
- R3: The subtract-type opcodes are SUB=2 (a−b), SBC=6 (a−b+C−1), RSB=3 (b−a), RSC=7 (b−a+C−1) and CMP=10 (a−b). The result wraps modulo 2^32, and the carry flag is the inverse of the borrow.
- R4: On every add-type or subtract-type opcode that updates the flags, the overflow flag is set when the true signed result falls outside the 32-bit two's-complement range.
- R5: The logical opcodes AND=0 (a&b), EOR=1 (a^b), ORR=12 (a|b) and BIC=14 (a&~b) write their bitwise result.
- R6: MOV=13 writes b and MVN=15 writes ~b. For both, the value of a has no effect.
- R7: The compare/test opcodes TST=8 (a&b), TEQ=9 (a^b), CMP=10 and CMN=11 drive `wr_en_o` low. They update the flags whatever the value of `set_flags_i`. All other opcodes drive `wr_en_o` high.
- R8: The flags use bit 3 for N, bit 2 for Z, bit 1 for C and bit 0 for V. When the flags are updated, N is bit 31 of the operation's value and Z is set when that value is zero.
- R9: When a logical, move or test opcode updates the flags, C is taken from `shc_i` and V keeps the value of `flags_i[0]`.
- R10: When `set_flags_i` is low and the opcode is not a compare/test, `flags_o` equals `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request a flag update |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Shifted second operand |
| shc_i | input | 1 | Carry out of the shift stage |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination write-enable |
| flags_o | output | 4 | Registered new flags {N,Z,C,V} |

## Verification
The bench checks the signed-overflow boundaries 0x7FFFFFFF+1 and 0x80000000−1. A design that computed overflow from the unsigned carry would flag the wrong one of these two cases. It also checks equal-operand subtraction and a subtraction that borrows, because an adder that kept the raw borrow instead of its inverse would give the wrong C on both. The carry-in forms SBC and RSC are run with C clear, which exposes an off-by-one in the borrow term. The reversed forms RSB and RSC catch swapped operands. Every compare/test is run with set-flags low, which catches a design that gates their flag update or lets them write. Logical operations are run with the shifter carry opposite to the incoming carry and with V set, which shows a design that takes C from the adder or clears V.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  // Compare/test forms occupy codes 8..11.
  function automatic logic op_is_test(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                       OP_CMP, OP_CMN});
  endfunction

endpackage

// File: rtl/dp_arith_unit.sv
module dp_arith_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic               carry_in,
  output logic [WIDTH-1:0]   sum,
  output logic               carry_out,
  output logic               ovf
);
  localparam int XW  = WIDTH + 1;
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             ci;
  logic [XW-1:0]    ext;

  // Subtraction is x + ~y + ci; ci = C gives x - y + C - 1.
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: begin x = a; y = b;  ci = 1'b0;     end
      OP_ADC:         begin x = a; y = b;  ci = carry_in; end
      OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1;     end
      OP_SBC:         begin x = a; y = ~b; ci = carry_in; end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1;     end
      OP_RSC:         begin x = b; y = ~a; ci = carry_in; end
      default:        begin x = a; y = b;  ci = 1'b0;     end
    endcase
  end

  assign ext       = {1'b0, x} + {1'b0, y} + XW'(ci);
  assign sum       = ext[MSB:0];
  assign carry_out = ext[WIDTH];
  assign ovf       = (x[MSB] == y[MSB]) && (ext[MSB] != x[MSB]);

endmodule

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_BIC:         y = a & ~b;
      OP_MOV:         y = b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/dp_flag_unit.sv
module dp_flag_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic             set_flags,
  input  logic [WIDTH-1:0] value,
  input  logic             arith_c,
  input  logic             arith_v,
  input  logic             shift_c,
  input  alu_flags_t       flags_in,
  output alu_flags_t       flags_out,
  output logic             wr_en
);
  logic update;
  logic arith;

  assign arith  = op_is_arith(op);
  assign update = set_flags | op_is_test(op);
  assign wr_en  = !op_is_test(op);

  always_comb begin
    flags_out = flags_in;
    if (update) begin
      flags_out.n = value[WIDTH-1];
      flags_out.z = (value == '0);
      flags_out.c = arith ? arith_c : shift_c;
      flags_out.v = arith ? arith_v : flags_in.v;
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             shc_i,
  input  logic [3:0]       flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  alu_op_e          op;
  alu_flags_t       fl_in, fl_nxt;
  logic [WIDTH-1:0] arith_y, logic_y, value;
  logic             arith_c, arith_v, wr_nxt;

  assign op    = alu_op_e'(op_i);
  assign fl_in = alu_flags_t'(flags_i);

  dp_arith_unit #(.WIDTH(WIDTH)) u_arith (
    .op(op), .a(a_i), .b(b_i), .carry_in(fl_in.c),
    .sum(arith_y), .carry_out(arith_c), .ovf(arith_v)
  );

  dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op(op), .a(a_i), .b(b_i), .y(logic_y)
  );

  assign value = op_is_arith(op) ? arith_y : logic_y;

  dp_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .op(op), .set_flags(set_flags_i), .value(value),
    .arith_c(arith_c), .arith_v(arith_v), .shift_c(shc_i),
    .flags_in(fl_in), .flags_out(fl_nxt), .wr_en(wr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
    end else begin
      result_o <= value;
      wr_en_o  <= wr_nxt;
      flags_o  <= fl_nxt;
    end
  end

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_i[3:2] == 2'b10) |=> !wr_en_o); // R7
  AST_TEST_SETS_Z: assert property (@(posedge clk) disable iff (rst)
    (op_i[3:2] == 2'b10 && !set_flags_i) |=> (flags_o[2] == (result_o == '0))); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_flags_i && op_i[3:2] != 2'b10) |=> (flags_o == $past(flags_i))); // R10
  AST_N_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (set_flags_i) |=> (flags_o[3] == result_o[WIDTH-1])); // R8
  AST_MOVE_PASS: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd13) |=> (result_o == $past(b_i))); // R6
  AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (rst)
    (set_flags_i && !op_is_arith(op)) |=> (flags_o[0] == $past(flags_i[0]))); // R9
  AST_LOGIC_C_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (set_flags_i && !op_is_arith(op)) |=> (flags_o[1] == $past(shc_i))); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !wr_en_o && flags_o == '0)); // R1

endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op_i;
  logic        set_flags_i;
  logic [31:0] a_i, b_i;
  logic        shc_i;
  logic [3:0]  flags_i;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dp_alu u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .set_flags_i(set_flags_i),
    .a_i(a_i), .b_i(b_i), .shc_i(shc_i), .flags_i(flags_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference: add form p+q+ci, or sub form p-q-(1-ci), with wide integers.
  task automatic ref_arith(input logic [31:0] p, input logic [31:0] q, input logic ci,
                           input bit sub, output logic [31:0] r, output logic c,
                           output logic v);
    longint us, ss;
    if (sub) begin
      us = longint'(p) - longint'(q) - longint'(1 - ci);
      ss = longint'($signed(p)) - longint'($signed(q)) - longint'(1 - ci);
      c  = (us >= 0);
    end else begin
      us = longint'(p) + longint'(q) + longint'(ci);
      ss = longint'($signed(p)) + longint'($signed(q)) + longint'(ci);
      c  = (us > 64'sh0FFFF_FFFF);
    end
    r = us[31:0];
    v = (ss > 64'sh7FFF_FFFF) || (ss < -64'sh8000_0000);
  endtask

  task automatic run(string req, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic set, input logic shc,
                     input logic [3:0] fin);
    logic [31:0] r;
    logic        c, v, arith, test, upd;
    logic [3:0]  fexp;
    arith = 1'b1;
    c = 1'b0; v = 1'b0; r = '0;
    case (op)
      4'd4, 4'd11: ref_arith(a, b, 1'b0, 0, r, c, v);
      4'd5:        ref_arith(a, b, fin[1], 0, r, c, v);
      4'd2, 4'd10: ref_arith(a, b, 1'b1, 1, r, c, v);
      4'd6:        ref_arith(a, b, fin[1], 1, r, c, v);
      4'd3:        ref_arith(b, a, 1'b1, 1, r, c, v);
      4'd7:        ref_arith(b, a, fin[1], 1, r, c, v);
      default: begin
        arith = 1'b0;
        case (op)
          4'd0, 4'd8: r = a & b;
          4'd1, 4'd9: r = a ^ b;
          4'd12:      r = a | b;
          4'd14:      r = a & ~b;
          4'd13:      r = b;
          default:    r = ~b;
        endcase
      end
    endcase
    test = (op >= 4'd8 && op <= 4'd11);
    upd  = set || test;
    if (upd) fexp = {r[31], r == 0, arith ? c : shc, arith ? v : fin[0]};
    else     fexp = fin;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; set_flags_i = set; shc_i = shc; flags_i = fin;
    @(posedge clk);
    #3;
    check(req, "wr_en", {31'b0, wr_en_o}, {31'b0, !test});
    if (!test) check(req, "result", result_o, r);
    check(req, "flags", {28'b0, flags_o}, {28'b0, fexp});
  endtask

  task automatic t_reset;
    rst = 1'b1; op_i = 4'd4; a_i = 32'h1234; b_i = 32'h1; set_flags_i = 1'b1;
    shc_i = 1'b1; flags_i = 4'hF;
    repeat (2) @(posedge clk);
    #3;
    check("R1", "reset result", result_o, 32'h0);
    check("R1", "reset wr_en", {31'b0, wr_en_o}, 32'h0);
    check("R1", "reset flags", {28'b0, flags_o}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add;
    run("R2", 4'd4, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b0, 4'h0);
    run("R2", 4'd5, 32'h10, 32'h20, 1'b1, 1'b0, 4'b0010);
    run("R2", 4'd5, 32'h10, 32'h20, 1'b1, 1'b0, 4'b0000);
    run("R4", 4'd4, 32'h7FFF_FFFF, 32'h1, 1'b1, 1'b0, 4'h0);
    run("R4", 4'd4, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 4'h0);
  endtask

  task automatic t_sub;
    run("R3", 4'd2, 32'd5, 32'd5, 1'b1, 1'b0, 4'h0);
    run("R3", 4'd2, 32'd3, 32'd5, 1'b1, 1'b0, 4'h0);
    run("R3", 4'd6, 32'd10, 32'd3, 1'b1, 1'b0, 4'b0000);
    run("R3", 4'd6, 32'd10, 32'd3, 1'b1, 1'b0, 4'b0010);
    run("R3", 4'd3, 32'd3, 32'd10, 1'b1, 1'b0, 4'h0);
    run("R3", 4'd7, 32'd3, 32'd10, 1'b1, 1'b0, 4'b0000);
    run("R3", 4'd7, 32'd10, 32'd3, 1'b1, 1'b0, 4'b0010);
    run("R4", 4'd2, 32'h8000_0000, 32'h1, 1'b1, 1'b0, 4'h0);
    run("R4", 4'd3, 32'h1, 32'h8000_0000, 1'b1, 1'b0, 4'h0);
  endtask

  task automatic t_logic;
    run("R5", 4'd0, 32'hF0F0_1234, 32'hFF00_FF00, 1'b1, 1'b1, 4'b0001);
    run("R5", 4'd1, 32'hAAAA_5555, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'b0011);
    run("R5", 4'd12, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, 4'b0001);
    run("R5", 4'd14, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1'b1, 1'b1, 4'b0000);
    run("R9", 4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 4'b0001);
    run("R9", 4'd1, 32'h1, 32'h1, 1'b1, 1'b0, 4'b0011);
  endtask

  task automatic t_move;
    run("R6", 4'd13, 32'h0, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'h0);
    run("R6", 4'd13, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 1'b0, 1'b0, 4'h0);
    run("R6", 4'd15, 32'h1234_5678, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b0001);
    run("R6", 4'd15, 32'h0, 32'h0, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_test;
    run("R7", 4'd10, 32'd7, 32'd7, 1'b0, 1'b0, 4'h0);
    run("R7", 4'd11, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 4'b1000);
    run("R7", 4'd8, 32'hF000_0000, 32'h8000_0000, 1'b0, 1'b0, 4'b0011);
    run("R7", 4'd9, 32'h55, 32'h55, 1'b0, 1'b1, 4'b0001);
    run("R8", 4'd10, 32'd1, 32'd2, 1'b1, 1'b0, 4'h0);
  endtask

  task automatic t_hold;
    run("R10", 4'd4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 4'b1010);
    run("R10", 4'd2, 32'd0, 32'd0, 1'b0, 1'b1, 4'b0101);
    run("R10", 4'd14, 32'h0, 32'h0, 1'b0, 1'b1, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_move();
    t_test();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule